// File: doc/BRIEF.md
# Synchronous Burst Bus Link with Slave Wait States

This block pairs a bus master engine with a bus slave engine on one clocked, shared bus. A user on the master side hands over a command: a direction, a start address and a word count. The master then raises its request and does nothing more until the grant input is high. Once granted, it spends exactly one cycle on a command/address phase. The data words follow. The slave owns a small word store and decodes the command. It can hold a wait line high to stall the transfer: for a fixed number of cycles after every command, and in any further cycle in which its not-ready input is set.

While wait is low, one word moves on every clock. A burst carries a single start address, and both sides step their address by one per word, wrapping at the top of the store. The master keeps its request up until the last word has moved. If the grant is taken away during the command or data phase, the master abandons the transaction and raises a sticky error flag. The slave sees the master stop driving the bus and returns to idle.

Top module: `sbus_burst_link`

## Requirements
- R1: After reset, req, rd_valid, done, proto_err, wr_take, bus_wait and addr_phase are 0, and cmd_ready is 1.
- R2: A command accepted while cmd_ready is high raises req from the next cycle. No address phase occurs in any cycle while grant is low.
- R3: The address phase (addr_phase high) lasts one cycle. It starts the cycle after the first cycle in which req and grant are both high.
- R4: For FIRST_LAT cycles after the address phase, and in any data cycle where slv_hold is 1, bus_wait is 1. No word moves while bus_wait is 1 (wr_take low, no rd_valid in the next cycle).
- R5: In a data cycle with bus_wait low and grant high, exactly one word moves.
- R6: A burst moves cmd_len+1 words, using cmd_addr, cmd_addr+1, … modulo 2^AW. Only one address phase is used.
- R7: For a read, rd_valid is high for one cycle, one cycle after each word moves. rd_data then equals the word stored at that word's address.
- R8: For a write, the word on wr_data is stored only in a cycle where wr_take is 1. wr_take stays 0 during reads and wait cycles.
- R9: req stays high until the last word has moved. In the next cycle req is 0, done pulses for one cycle, and cmd_ready is 1.
- R10: Losing grant in the address or data phase moves no word in that cycle. In the next cycle req drops and proto_err becomes 1, and the remaining words are abandoned. proto_err stays 1 until the next command is accepted.
- R11: cmd_valid while cmd_ready is low is ignored. No second transaction follows the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Bus grant from the arbiter |
| req | output | 1 | Bus request from the master |
| cmd_valid | input | 1 | New command offered by the master-side user |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | AW | Start word address |
| cmd_len | input | LW | Number of words minus one |
| cmd_ready | output | 1 | Master idle and able to take a command |
| wr_data | input | DW | Current write word, held until taken |
| wr_take | output | 1 | Write word consumed this cycle |
| rd_valid | output | 1 | Read word available |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle pulse after a completed transaction |
| proto_err | output | 1 | Sticky flag for grant lost mid-transaction |
| slv_hold | input | 1 | Slave not ready, forces a wait cycle |
| bus_wait | output | 1 | Wait line driven by the slave |
| addr_phase | output | 1 | Command/address phase on the bus |

## Verification
The bench counts the cycle in which each result is due. req appears one cycle after command accept. addr_phase comes one cycle after the first cycle that has both req and grant. Then come FIRST_LAT cycles of forced wait. bus_wait and wr_take respond within the same cycle to slv_hold and grant. rd_valid and its data follow a moved word by one cycle. done, the drop of req and a new proto_err all appear one cycle after the last or aborted data cycle. Inputs are driven on the falling edge. Outputs are sampled either at that edge or, for outputs that depend on inputs set in the same cycle, 1 ns after those inputs change. Each check is therefore tied to one known cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_REQ  = 2'd1,
    M_CMD  = 2'd2,
    M_DATA = 2'd3
  } mst_state_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_DATA = 1'b1
  } slv_state_e;

endpackage

// File: rtl/sbus_master.sv
module sbus_master
  import sbus_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  output logic          req,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  output logic          cmd_ready,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          proto_err,
  input  logic          bus_wait,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_cmd,
  output logic          bus_own,
  output logic          bus_rw,
  output logic [AW-1:0] bus_addr,
  output logic [LW-1:0] bus_len,
  output logic [DW-1:0] bus_wdata
);

  localparam logic [LW-1:0] L_ONE = LW'(1);

  mst_state_e    state_q, state_d;
  logic          rw_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          err_d, err_q;
  logic          rdv_q;
  logic [DW-1:0] rdd_q;
  logic          done_q;

  logic accept, xfer, last, abort, cnt_en, cmd_en, rdd_en;

  always_comb begin
    accept    = (state_q == M_IDLE) && cmd_valid;
    xfer      = (state_q == M_DATA) && grant && !bus_wait;
    last      = xfer && (cnt_q == len_q);
    abort     = ((state_q == M_CMD) || (state_q == M_DATA)) && !grant;
    cmd_en    = accept;
    cnt_en    = accept || xfer;
    rdd_en    = xfer && !rw_q;
    req       = (state_q != M_IDLE);
    cmd_ready = (state_q == M_IDLE);
    bus_cmd   = (state_q == M_CMD) && grant;
    bus_own   = ((state_q == M_CMD) || (state_q == M_DATA)) && grant;
    bus_rw    = bus_cmd ? rw_q : 1'b0;
    bus_addr  = bus_cmd ? addr_q : '0;
    bus_len   = bus_cmd ? len_q : '0;
    bus_wdata = ((state_q == M_DATA) && grant && rw_q) ? wr_data : '0;
    wr_take   = xfer && rw_q;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      M_IDLE: if (cmd_valid) state_d = M_REQ;
      M_REQ:  if (grant) state_d = M_CMD;
      M_CMD:  state_d = grant ? M_DATA : M_IDLE;
      M_DATA: if (!grant || last) state_d = M_IDLE;
      default: state_d = M_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = accept ? '0 : (cnt_q + L_ONE);
    err_d = err_q;
    if (abort) err_d = 1'b1;
    else if (accept) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      rdv_q   <= rdd_en;
      done_q  <= last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (cmd_en) begin
      rw_q   <= cmd_write;
      addr_q <= cmd_addr;
      len_q  <= cmd_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdd_q <= '0;
    else if (rdd_en) rdd_q <= bus_rdata;
  end

  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign done      = done_q;
  assign proto_err = err_q;

endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int LW        = 2,
  parameter int FIRST_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slv_hold,
  input  logic          bus_cmd,
  input  logic          bus_own,
  input  logic          bus_rw,
  input  logic [AW-1:0] bus_addr,
  input  logic [LW-1:0] bus_len,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_wait,
  output logic [DW-1:0] bus_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [LW-1:0] L_ONE = LW'(1);

  slv_state_e    state_q, state_d;
  logic          rw_q;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          start, active, xfer, lat_busy;

  always_comb begin
    start    = (state_q == S_IDLE) && bus_cmd;
    active   = (state_q == S_DATA);
    bus_wait = active && (lat_busy || slv_hold);
    xfer     = active && bus_own && !bus_wait;
    addr_d   = start ? bus_addr : (addr_q + A_ONE);
    cnt_d    = start ? '0 : (cnt_q + L_ONE);
  end

  generate
    if (FIRST_LAT > 0) begin : g_lat
      localparam int LATW = $clog2(FIRST_LAT + 1);
      localparam logic [LATW-1:0] LAT_INIT = LATW'(FIRST_LAT);
      localparam logic [LATW-1:0] LAT_ONE  = LATW'(1);
      logic [LATW-1:0] lat_q, lat_d;
      logic            lat_en;
      always_comb begin
        lat_en = start || (active && (lat_q != '0));
        lat_d  = start ? LAT_INIT : (lat_q - LAT_ONE);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else if (lat_en) lat_q <= lat_d;
      end
      assign lat_busy = (lat_q != '0);
    end else begin : g_nolat
      assign lat_busy = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (bus_cmd) state_d = S_DATA;
      S_DATA: if (!bus_own || (xfer && (cnt_q == len_q))) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q  <= 1'b0;
      len_q <= '0;
    end else if (start) begin
      rw_q  <= bus_rw;
      len_q <= bus_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (start || xfer) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mem_we    = xfer && rw_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = bus_wdata;
  assign bus_rdata = (xfer && !rw_q) ? mem_rdata : '0;

endmodule

// File: rtl/sbus_slave_mem.sv
module sbus_slave_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];

endmodule

// File: rtl/sbus_burst_link.sv
module sbus_burst_link #(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int LW        = 2,
  parameter int FIRST_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  output logic          req,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  output logic          cmd_ready,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          proto_err,
  input  logic          slv_hold,
  output logic          bus_wait,
  output logic          addr_phase
);

  logic          b_cmd, b_own, b_rw;
  logic [AW-1:0] b_addr;
  logic [LW-1:0] b_len;
  logic [DW-1:0] b_wdata, b_rdata;
  logic          m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  sbus_master #(.AW(AW), .DW(DW), .LW(LW)) u_master (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_ready(cmd_ready), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .proto_err(proto_err), .bus_wait(bus_wait),
    .bus_rdata(b_rdata), .bus_cmd(b_cmd), .bus_own(b_own), .bus_rw(b_rw),
    .bus_addr(b_addr), .bus_len(b_len), .bus_wdata(b_wdata)
  );

  sbus_slave #(.AW(AW), .DW(DW), .LW(LW), .FIRST_LAT(FIRST_LAT)) u_slave (
    .clk(clk), .rst_n(rst_n), .slv_hold(slv_hold), .bus_cmd(b_cmd),
    .bus_own(b_own), .bus_rw(b_rw), .bus_addr(b_addr), .bus_len(b_len),
    .bus_wdata(b_wdata), .bus_wait(bus_wait), .bus_rdata(b_rdata),
    .mem_we(m_we), .mem_addr(m_addr), .mem_wdata(m_wdata),
    .mem_rdata(m_rdata)
  );

  sbus_slave_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
  );

  assign addr_phase = b_cmd;

endmodule

// File: rtl/sbus_link_checker.sv
module sbus_link_checker (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic req,
  input logic addr_phase,
  input logic bus_wait,
  input logic wr_take,
  input logic rd_valid,
  input logic done,
  input logic proto_err
);

  assert_addr_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> (grant && req));

  assert_addr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);

  assert_wait_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> !wr_take);

  assert_wait_in_txn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> req);

  assert_rd_follows_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(req) && !$past(bus_wait)));

  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req && $past(req)));

  assert_release_reason_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> (done || proto_err));

  assert_err_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> !req);

endmodule

bind sbus_burst_link sbus_link_checker u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req),
  .addr_phase(addr_phase), .bus_wait(bus_wait), .wr_take(wr_take),
  .rd_valid(rd_valid), .done(done), .proto_err(proto_err)
);

// File: tb/tb_sbus_burst_link.sv
module tb_sbus_burst_link;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 2;
  localparam int FIRST_LAT = 1;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 8;

  // vector: {write, addr[3:0], len[1:0], hold_mask[7:0]}
  localparam logic [14:0] VECS [NVEC] = '{
    {1'b1, 4'd2,  2'd3, 8'h00},
    {1'b0, 4'd2,  2'd3, 8'h00},
    {1'b1, 4'd14, 2'd3, 8'h05},
    {1'b0, 4'd14, 2'd3, 8'h02},
    {1'b1, 4'd7,  2'd0, 8'h03},
    {1'b0, 4'd7,  2'd0, 8'h00},
    {1'b0, 4'd0,  2'd1, 8'h01},
    {1'b1, 4'd12, 2'd0, 8'h00}
  };

  logic          clk, rst_n, grant, req, cmd_valid, cmd_write, cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_take, rd_valid, done, proto_err, slv_hold, bus_wait, addr_phase;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  sbus_burst_link #(.AW(AW), .DW(DW), .LW(LW), .FIRST_LAT(FIRST_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_ready(cmd_ready), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .proto_err(proto_err), .slv_hold(slv_hold),
    .bus_wait(bus_wait), .addr_phase(addr_phase)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wval(input int vid, input int k);
    return DW'(16'h1000 * (vid + 1) + 16'h0011 * k + 16'h0003);
  endfunction

  task automatic run_txn(input bit wr, input int addr, input int len,
                         input logic [7:0] hold, input int vid, input bit intrude);
    int words = 0;
    int j = 0;
    logic prev_rd = 1'b0;
    logic [DW-1:0] prev_exp = '0;
    check("R9 cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = AW'(addr); cmd_len = LW'(len);
    grant = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 req after accept", req, 1);
    check("R10 err cleared on accept", proto_err, 0);
    if (intrude) begin
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd5; cmd_len = 2'd1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 no address phase without grant", addr_phase, 0);
    grant = 1'b1;
    @(negedge clk);
    check("R3 address phase", addr_phase, 1);
    @(negedge clk);
    check("R3 address phase one cycle", addr_phase, 0);
    for (int i = 0; i < FIRST_LAT; i++) begin
      check("R4 first latency wait", bus_wait, 1);
      check("R4 no take in wait", wr_take, 0);
      @(negedge clk);
    end
    while (words <= len) begin
      check("R7 rd_valid timing", rd_valid, prev_rd);
      if (prev_rd) check("R7 rd_data", rd_data, prev_exp);
      slv_hold = (j < 8) ? hold[j] : 1'b0;
      wr_data = wval(vid, words);
      #1;
      check("R4 wait follows hold", bus_wait, slv_hold);
      check("R5 R8 wr_take", wr_take, wr && !slv_hold);
      check("R9 req held in burst", req, 1);
      prev_rd = !wr && !slv_hold;
      prev_exp = model[(addr + words) % DEPTH];
      if (!slv_hold) begin
        if (wr) model[(addr + words) % DEPTH] = wr_data;
        words++;
      end
      j++;
      @(negedge clk);
    end
    slv_hold = 1'b0;
    check("R7 last rd_valid", rd_valid, prev_rd);
    if (prev_rd) check("R7 last rd_data", rd_data, prev_exp);
    check("R9 req released", req, 0);
    check("R9 done pulse", done, 1);
    check("R9 cmd_ready back", cmd_ready, 1);
    check("R6 burst length ok", 32'(words), 32'(len + 1));
    grant = 1'b0;
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    if (intrude) check("R11 busy command ignored", req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; grant = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_len = '0; wr_data = '0; slv_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req", req, 0);
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 done", done, 0);
    check("R1 proto_err", proto_err, 0);
    check("R1 wr_take", wr_take, 0);
    check("R1 bus_wait", bus_wait, 0);
    check("R1 addr_phase", addr_phase, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_txn(VECS[v][14], int'(VECS[v][13:10]), int'(VECS[v][9:8]),
              VECS[v][7:0], v, 1'b0);
    end

    // R11: command offered while busy
    run_txn(1'b1, 9, 0, 8'h00, 20, 1'b1);

    // R10: grant lost in the middle of a write burst at address 11
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd11; cmd_len = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    grant = 1'b1;
    @(negedge clk);
    check("R3 address phase before abort", addr_phase, 1);
    @(negedge clk);
    for (int i = 0; i < FIRST_LAT; i++) @(negedge clk);
    wr_data = wval(30, 0);
    #1;
    check("R10 first word moves", wr_take, 1);
    model[11] = wr_data;
    @(negedge clk);
    grant = 1'b0;
    wr_data = wval(30, 1);
    #1;
    check("R10 no word without grant", wr_take, 0);
    @(negedge clk);
    check("R10 proto_err set", proto_err, 1);
    check("R10 req dropped", req, 0);
    check("R10 no done on abort", done, 0);
    @(negedge clk);
    check("R10 proto_err sticky", proto_err, 1);
    // read back: word 11 new, word 12 keeps the old value
    run_txn(1'b0, 11, 1, 8'h00, 31, 1'b0);
    check("R10 err cleared", proto_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule